// File: doc/BRIEF.md
# Completion Interrupt Credit Moderator

This block paces completion interrupts for a single descriptor ring. It keeps a credit count: the number of descriptors the device has finished that the driver has not yet taken. The DMA engine pulses a strobe for each finished descriptor. The driver writes back, through the register port, the number of descriptors it has consumed. The block raises an interrupt request pulse only when the driver needs to act.

After an interrupt the block masks itself. This self-mask is separate from any mask bit in the message-signalled interrupt vector table, and the block never changes that table. While self-masked, further completions only add to the count. A credit write that returns everything the driver owes clears the self-mask quietly. A credit write that leaves work outstanding fires one more interrupt so the driver comes back. A ring reset returns the block to its idle state.

Top module: `irq_credit_moderator`

## Requirements
- R1: Each cycle with `desc_done` high adds one to `credit_count`. The new value is visible on the clock edge that samples the strobe.
- R2: A cycle with `credit_wr` high subtracts `credit_val` from the count. If `desc_done` is high in the same cycle, the completion is added first and the returned value is subtracted afterwards.
- R3: A completion that arrives while the block is not self-masked, with no credit write in the same cycle, raises `irq_pulse` for exactly one cycle after the sampling edge and sets `auto_masked`.
- R4: A credit write whose result is zero clears `auto_masked` and raises no interrupt.
- R5: A credit write whose result is non-zero raises `irq_pulse` for one cycle and leaves `auto_masked` set.
- R6: Completions that arrive while `auto_masked` is set, with no credit write, raise no interrupt.
- R7: If a credit write returns more than the outstanding count, the count becomes zero and `underflow_err` is set. The flag stays set until a ring reset or a block reset.
- R8: The count saturates at all ones (15 when `CNT_W` is 4). It never wraps to zero.
- R9: `ring_reset` overrides every other input in its cycle. It clears the count, `auto_masked` and `underflow_err`, and suppresses any interrupt.
- R10: `irq_pulse` is never high while `auto_masked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ring_reset | input | 1 | Synchronous ring reset strobe |
| desc_done | input | 1 | One descriptor completed by the device |
| credit_wr | input | 1 | Driver credit-return write strobe |
| credit_val | input | CNT_W | Number of credits returned with `credit_wr` |
| credit_count | output | CNT_W | Outstanding credit count |
| auto_masked | output | 1 | Self-mask state |
| irq_pulse | output | 1 | Interrupt request, one cycle per trigger |
| underflow_err | output | 1 | Sticky flag for an over-return of credits |

## Verification
The bench builds the block with `CNT_W` set to 4. At that width the ceiling of 15 is reached in a few completions, so saturation and the return of a full saturated count can be exercised directly. The narrow `credit_val` also makes over-returns common during the mixed random phase. That phase also produces many cycles where a completion and a credit write coincide, so the add-then-subtract ordering is tested against the reference model many times.

// File: rtl/cmod_pkg.sv
package cmod_pkg;

  typedef enum logic {
    MASK_OFF = 1'b0,
    MASK_ON  = 1'b1
  } mask_e;

endpackage

// File: rtl/cmod_credit_ctr.sv
module cmod_credit_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_reset,
  input  logic             desc_done,
  input  logic             credit_wr,
  input  logic [CNT_W-1:0] credit_val,
  output logic [CNT_W-1:0] count_q,
  output logic             err_q,
  output logic             next_zero,
  output logic             uf_event
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] f_sat_inc(input logic [CNT_W-1:0] v, input logic en);
    if (!en || v == CNT_MAX) return v;
    return v + CNT_ONE;
  endfunction

  function automatic logic f_over(input logic [CNT_W-1:0] v, input logic [CNT_W-1:0] d);
    return d > v;
  endfunction

  function automatic logic [CNT_W-1:0] f_sat_sub(input logic [CNT_W-1:0] v, input logic [CNT_W-1:0] d);
    if (f_over(v, d)) return '0;
    return v - d;
  endfunction

  logic [CNT_W-1:0] inc_val;
  logic [CNT_W-1:0] after_ret;

  always_comb begin
    inc_val   = f_sat_inc(count_q, desc_done);
    after_ret = credit_wr ? f_sat_sub(inc_val, credit_val) : inc_val;
    uf_event  = credit_wr && f_over(inc_val, credit_val);
    next_zero = (after_ret == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      err_q   <= 1'b0;
    end else if (ring_reset) begin
      count_q <= '0;
      err_q   <= 1'b0;
    end else begin
      count_q <= after_ret;
      if (uf_event) err_q <= 1'b1;
    end
  end

endmodule

// File: rtl/cmod_mask_ctl.sv
module cmod_mask_ctl
  import cmod_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ring_reset,
  input  logic  desc_done,
  input  logic  credit_wr,
  input  logic  next_zero,
  output mask_e mask_q,
  output logic  irq_q,
  output logic  fire_event
);

  logic  fire_first;
  logic  fire_remain;
  mask_e mask_d;

  always_comb begin
    fire_first  = desc_done && !credit_wr && (mask_q == MASK_OFF);
    fire_remain = credit_wr && !next_zero;
    fire_event  = !ring_reset && (fire_first || fire_remain);
    if (ring_reset)     mask_d = MASK_OFF;
    else if (credit_wr) mask_d = next_zero ? MASK_OFF : MASK_ON;
    else if (desc_done) mask_d = MASK_ON;
    else                mask_d = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_OFF;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= fire_event;
    end
  end

endmodule

// File: rtl/irq_credit_moderator.sv
module irq_credit_moderator
  import cmod_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_reset,
  input  logic             desc_done,
  input  logic             credit_wr,
  input  logic [CNT_W-1:0] credit_val,
  output logic [CNT_W-1:0] credit_count,
  output logic             auto_masked,
  output logic             irq_pulse,
  output logic             underflow_err
);

  logic [CNT_W-1:0] ctr_count;
  logic             ctr_err;
  logic             next_zero;
  logic             uf_event;
  logic             fire_event;
  logic             irq_q;
  mask_e            mask_st;

  cmod_credit_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_reset (ring_reset),
    .desc_done  (desc_done),
    .credit_wr  (credit_wr),
    .credit_val (credit_val),
    .count_q    (ctr_count),
    .err_q      (ctr_err),
    .next_zero  (next_zero),
    .uf_event   (uf_event)
  );

  cmod_mask_ctl u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_reset (ring_reset),
    .desc_done  (desc_done),
    .credit_wr  (credit_wr),
    .next_zero  (next_zero),
    .mask_q     (mask_st),
    .irq_q      (irq_q),
    .fire_event (fire_event)
  );

  assign credit_count  = ctr_count;
  assign underflow_err = ctr_err;
  assign auto_masked   = (mask_st == MASK_ON);
  assign irq_pulse     = irq_q;

endmodule

// File: rtl/cmod_checker.sv
module cmod_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ring_reset,
  input logic             desc_done,
  input logic             credit_wr,
  input logic [CNT_W-1:0] credit_val,
  input logic [CNT_W-1:0] credit_count,
  input logic             auto_masked,
  input logic             irq_pulse,
  input logic             underflow_err,
  input logic             uf_event
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_done && !credit_wr && !ring_reset && credit_count != CNT_MAX)
      |=> credit_count == $past(credit_count) + 1'b1);

  p_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_wr && !desc_done && !ring_reset && credit_val <= credit_count)
      |=> credit_count == $past(credit_count) - $past(credit_val));

  p_first_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_done && !credit_wr && !ring_reset && !auto_masked)
      |=> irq_pulse && auto_masked);

  p_return_r4_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_wr && !ring_reset)
      |=> ((credit_count == '0) ? (!irq_pulse && !auto_masked) : (irq_pulse && auto_masked)));

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_done && !credit_wr && !ring_reset && auto_masked) |=> !irq_pulse);

  p_uf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_event && !ring_reset) |=> underflow_err && credit_count == '0);

  p_uf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_err && !ring_reset) |=> underflow_err);

  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_count == CNT_MAX && desc_done && !credit_wr && !ring_reset)
      |=> credit_count == CNT_MAX);

  p_ring_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ring_reset |=> credit_count == '0 && !auto_masked && !irq_pulse && !underflow_err);

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> auto_masked);

endmodule

bind irq_credit_moderator cmod_checker #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ring_reset    (ring_reset),
  .desc_done     (desc_done),
  .credit_wr     (credit_wr),
  .credit_val    (credit_val),
  .credit_count  (credit_count),
  .auto_masked   (auto_masked),
  .irq_pulse     (irq_pulse),
  .underflow_err (underflow_err),
  .uf_event      (uf_event)
);

// File: tb/irq_credit_moderator_tb.sv
`timescale 1ns/1ps
module irq_credit_moderator_tb_top;

  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ring_reset = 1'b0;
  logic         desc_done = 1'b0;
  logic         credit_wr = 1'b0;
  logic [W-1:0] credit_val = '0;
  logic [W-1:0] credit_count;
  logic         auto_masked;
  logic         irq_pulse;
  logic         underflow_err;

  int  n_vec  = 0;
  int  n_bad  = 0;
  bit  finished = 1'b0;

  int  m_cnt  = 0;
  bit  m_mask = 0;
  bit  m_irq  = 0;
  bit  m_err  = 0;

  always #2 clk = ~clk;

  irq_credit_moderator #(.CNT_W(W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ring_reset    (ring_reset),
    .desc_done     (desc_done),
    .credit_wr     (credit_wr),
    .credit_val    (credit_val),
    .credit_count  (credit_count),
    .auto_masked   (auto_masked),
    .irq_pulse     (irq_pulse),
    .underflow_err (underflow_err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "credit_count", int'(credit_count), m_cnt);
    chk(tag, "auto_masked", int'(auto_masked), int'(m_mask));
    chk(tag, "irq_pulse", int'(irq_pulse), int'(m_irq));
    chk(tag, "underflow_err", int'(underflow_err), int'(m_err));
  endtask

  // Reference: completion is counted first, then the returned credits taken off.
  task automatic model(input bit d, input bit w, input int v, input bit r);
    int t;
    if (r) begin
      m_cnt = 0; m_mask = 0; m_irq = 0; m_err = 0;
    end else if (w) begin
      t = m_cnt + (d ? 1 : 0);
      if (t > MAXV) t = MAXV;
      if (v > t) begin
        m_err = 1;
        t = 0;
      end else begin
        t = t - v;
      end
      m_cnt  = t;
      m_irq  = (t != 0);
      m_mask = (t != 0);
    end else if (d) begin
      m_irq  = !m_mask;
      m_mask = 1;
      if (m_cnt < MAXV) m_cnt = m_cnt + 1;
    end else begin
      m_irq = 0;
    end
  endtask

  task automatic step(input bit d, input bit w, input int v, input bit r, input string tag);
    desc_done  = d;
    credit_wr  = w;
    credit_val = v[W-1:0];
    ring_reset = r;
    @(posedge clk);
    model(d, w, v, r);
    @(negedge clk);
    desc_done  = 1'b0;
    credit_wr  = 1'b0;
    ring_reset = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R9");
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 0, 0, "R9");
    // first completion fires and masks
    step(1, 0, 0, 0, "R3");
    // masked completions only count
    step(1, 0, 0, 0, "R6");
    step(1, 0, 0, 0, "R1");
    step(1, 0, 0, 0, "R6");
    // partial return fires again
    step(0, 1, 2, 0, "R5");
    // full return unmasks quietly
    step(0, 1, 2, 0, "R4");
    step(0, 0, 0, 0, "R4");
    step(1, 0, 0, 0, "R3");
    // same-cycle completion and return
    step(1, 1, 1, 0, "R2");
    step(1, 1, 2, 0, "R2");
    step(1, 0, 0, 0, "R3");
    // over-return
    step(0, 1, 5, 0, "R7");
    step(1, 0, 0, 0, "R7");
    step(0, 0, 0, 0, "R7");
    // saturation
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0, "R8");
    step(1, 1, 15, 0, "R8");
    step(1, 0, 0, 0, "R3");
    // ring reset beats other inputs
    step(1, 0, 0, 1, "R9");
    step(1, 0, 0, 0, "R3");
    step(1, 1, 0, 1, "R9");
    step(0, 1, 0, 0, "R4");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom % 16;
      step(sel[0], (sel % 5) == 1, $urandom % 6, (sel == 15), "R10");
    end
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule